// File: doc/BRIEF.md
# Paged PHY Register File

This block is the register space of a two-port serial-bus physical layer as the link layer sees it. The link reaches it through a 4-bit address, an 8-bit write path with a write strobe, and a combinational read path. The lower half of the address space (0 to 7) is a fixed base map. It holds two sticky event flags, the arbitration-acceleration and multi-speed enables, a resume watchdog enable and the selection register. The upper half (8 to 15) is a window. What appears in it depends on a page code and a port code held in the selection register.

The block watches each port's four status lines: connected, bias, disabled and fault. It compares them with a copy registered one cycle earlier. When an interrupt-enabled port changes, the port-event flag is raised. A resume pulse raises the same flag when the watchdog enable is set. A mode input can block the flag from being raised at all. A pulse from the arbitration logic raises the timeout flag. Both flags are cleared only by writing a one to them. The block holds no state machine: the only sequential behaviour is the sticky flags, the status history and the register storage.

Top module: `phy_regfile`

## Requirements
- R1: After reset, every register reads 0 (address 5, 6 and 7, the interrupt enables and the vendor-dependent bytes), and `accel_en` and `multi_en` are low.
- R2: Address 5 bit 7 is the timeout flag. A one-cycle `arb_timeout` pulse sets it. Writing 1 to bit 7 clears it, and writing 0 leaves it unchanged.
- R3: Address 5 bit 6 is the port-event flag. It is set on the clock edge after a port's status nibble changes, provided that port's interrupt enable is 1. A change on a port whose interrupt enable is 0 has no effect. A status that then holds steady does not set the flag again after it has been cleared by writing 1 to bit 6.
- R4: A `port_resume` pulse on any port sets the port-event flag only while the watchdog enable (address 6 bit 0, read/write) is 1.
- R5: While `susp_mode` is low, neither status changes nor resumes set the port-event flag.
- R6: If a set condition and a write-one-to-clear meet in the same cycle, the flag ends up set.
- R7: Address 5 bit 1 drives `accel_en` and bit 0 drives `multi_en`. Both are read/write. Bits 5 to 2 read 0.
- R8: Address 7 holds the page code in bits 7:5 and the port code in bits 3:0. Bit 4 reads 0.
- R9: On page 0 with a valid port code (0 or 1), address 8 reads the selected port's status in bits 7:4, ordered {connected, bias, disabled, fault}. Address 9 bit 0 is that port's read/write interrupt enable. Status bits are packed per port p at `port_status[4p+3:4p]` in the same order.
- R10: Page 1 reads the parameter constants, whatever the port code: addresses 8 to 10 give VENDOR_ID from the high byte down, addresses 11 to 13 give PRODUCT_ID from the high byte down, and 14 to 15 read 0.
- R11: Page 7 with port code 1 exposes eight read/write bytes at addresses 8 to 15. With any other port code, page 7 reads 0 and ignores writes.
- R12: Unused pages (2 to 6), and page 0 with a port code of 2 or above, read 0 and ignore writes.
- R13: Base addresses 0 to 4 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| port_status | input | 8 | Per-port {connected, bias, disabled, fault} nibbles |
| port_resume | input | 2 | Per-port resume pulses |
| arb_timeout | input | 1 | Arbitration timeout pulse |
| susp_mode | input | 1 | Suspend/resume mode; low blocks port events |
| accel_en | output | 1 | Arbitration acceleration enable |
| multi_en | output | 1 | Multi-speed concatenation enable |

## Verification
The bench targets write-one-to-clear edges. These are writing zero to a set flag, and a clear that collides with a fresh set. A design with the priority reversed would lose the event. The bench also changes the status of a port whose interrupt is disabled, and then holds a status steady after clearing. A design that compared against the wrong history would either flag the masked port or raise the event again. Finally, it writes through unused pages and port codes and reads the vendor-dependent bytes afterwards, which exposes a decoder that leaks writes into real storage.

// File: rtl/phy_regfile_pkg.sv
package phy_regfile_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int STAT_W = 4;

    localparam logic [2:0] A_FLAGS  = 3'd5;
    localparam logic [2:0] A_WDOG   = 3'd6;
    localparam logic [2:0] A_SELECT = 3'd7;

    localparam int B_TMO   = 7;
    localparam int B_EVT   = 6;
    localparam int B_ACCEL = 1;
    localparam int B_MULTI = 0;

    typedef enum logic [2:0] {
        PG_PSTAT = 3'd0,
        PG_VID   = 3'd1,
        PG_VDEP  = 3'd7
    } page_e;

    typedef enum logic [2:0] {
        WIN_BASE,
        WIN_PSTAT,
        WIN_VID,
        WIN_VDEP,
        WIN_NONE
    } win_e;

endpackage

// File: rtl/prf_sticky_flag.sv
module prf_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end
endmodule

// File: rtl/prf_change_det.sv
module prf_change_det #(
    parameter int NPORT  = 2,
    parameter int STAT_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT*STAT_W-1:0] status_i,
    input  logic [NPORT-1:0]        inten_i,
    output logic                    hit_o
);
    logic [NPORT-1:0] port_hit;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [STAT_W-1:0] prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                prev_q <= '0;
            else
                prev_q <= status_i[p*STAT_W +: STAT_W];
        end
        assign port_hit[p] = inten_i[p] && (prev_q != status_i[p*STAT_W +: STAT_W]);
    end

    assign hit_o = |port_hit;
endmodule

// File: rtl/prf_window_dec.sv
module prf_window_dec
    import phy_regfile_pkg::*;
#(
    parameter int NPORT     = 2,
    parameter int VDEP_PORT = 1
) (
    input  logic       upper_i,
    input  logic [2:0] page_i,
    input  logic [3:0] port_i,
    output win_e       win_o
);
    logic port_ok;
    assign port_ok = (int'(port_i) < NPORT);

    always_comb begin
        win_o = WIN_NONE;
        if (!upper_i) begin
            win_o = WIN_BASE;
        end else begin
            unique case (page_i)
                PG_PSTAT: win_o = port_ok ? WIN_PSTAT : WIN_NONE;
                PG_VID:   win_o = WIN_VID;
                PG_VDEP:  win_o = (int'(port_i) == VDEP_PORT) ? WIN_VDEP : WIN_NONE;
                default:  win_o = WIN_NONE;
            endcase
        end
    end
endmodule

// File: rtl/phy_regfile.sv
module phy_regfile
    import phy_regfile_pkg::*;
#(
    parameter int          NPORT      = 2,
    parameter int          VDEP_PORT  = 1,
    parameter logic [23:0] VENDOR_ID  = 24'h00A0B1,
    parameter logic [23:0] PRODUCT_ID = 24'h5C2D3E
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr_en,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    input  logic [NPORT*STAT_W-1:0] port_status,
    input  logic [NPORT-1:0]        port_resume,
    input  logic                    arb_timeout,
    input  logic                    susp_mode,
    output logic                    accel_en,
    output logic                    multi_en
);
    localparam int IDX_W    = (NPORT > 1) ? $clog2(NPORT) : 1;
    localparam int WIN_SPAN = 1 << (ADDR_W - 1);

    logic [2:0]        sel_page;
    logic [3:0]        sel_port;
    logic              wdog_q;
    logic              tmo_q;
    logic              evt_q;
    logic [NPORT-1:0]  inten_q;
    logic [DATA_W-1:0] vdep_q [WIN_SPAN];

    win_e              win;
    logic [2:0]        off;
    logic [IDX_W-1:0]  pidx;
    logic              stat_hit;
    logic              evt_set;
    logic              flags_wr;

    assign off      = addr[2:0];
    assign pidx     = sel_port[IDX_W-1:0];
    assign flags_wr = wr_en && (win == WIN_BASE) && (off == A_FLAGS);

    prf_window_dec #(.NPORT(NPORT), .VDEP_PORT(VDEP_PORT)) u_dec (
        .upper_i (addr[ADDR_W-1]),
        .page_i  (sel_page),
        .port_i  (sel_port),
        .win_o   (win)
    );

    prf_change_det #(.NPORT(NPORT), .STAT_W(STAT_W)) u_chg (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (port_status),
        .inten_i  (inten_q),
        .hit_o    (stat_hit)
    );

    assign evt_set = susp_mode && (stat_hit || (wdog_q && (|port_resume)));

    prf_sticky_flag u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (arb_timeout),
        .clr_i (flags_wr && wdata[B_TMO]),
        .q_o   (tmo_q)
    );

    prf_sticky_flag u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_set),
        .clr_i (flags_wr && wdata[B_EVT]),
        .q_o   (evt_q)
    );

    // Base map and window storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accel_en <= 1'b0;
            multi_en <= 1'b0;
            wdog_q   <= 1'b0;
            sel_page <= '0;
            sel_port <= '0;
            inten_q  <= '0;
        end else if (wr_en) begin
            if (win == WIN_BASE) begin
                unique case (off)
                    A_FLAGS: begin
                        accel_en <= wdata[B_ACCEL];
                        multi_en <= wdata[B_MULTI];
                    end
                    A_WDOG:   wdog_q <= wdata[0];
                    A_SELECT: begin
                        sel_page <= wdata[7:5];
                        sel_port <= wdata[3:0];
                    end
                    default: ;
                endcase
            end else if (win == WIN_PSTAT && off == 3'd1) begin
                inten_q[pidx] <= wdata[0];
            end
        end
    end

    for (genvar i = 0; i < WIN_SPAN; i++) begin : g_vdep
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                vdep_q[i] <= '0;
            else if (wr_en && win == WIN_VDEP && int'(off) == i)
                vdep_q[i] <= wdata;
        end
    end

    function automatic logic [DATA_W-1:0] vid_byte(input logic [2:0] o);
        unique case (o)
            3'd0:    return VENDOR_ID[23:16];
            3'd1:    return VENDOR_ID[15:8];
            3'd2:    return VENDOR_ID[7:0];
            3'd3:    return PRODUCT_ID[23:16];
            3'd4:    return PRODUCT_ID[15:8];
            3'd5:    return PRODUCT_ID[7:0];
            default: return '0;
        endcase
    endfunction

    // Read path
    always_comb begin
        rdata = '0;
        unique case (win)
            WIN_BASE: begin
                unique case (off)
                    A_FLAGS:  rdata = {tmo_q, evt_q, 4'b0, accel_en, multi_en};
                    A_WDOG:   rdata = {7'b0, wdog_q};
                    A_SELECT: rdata = {sel_page, 1'b0, sel_port};
                    default:  rdata = '0;
                endcase
            end
            WIN_PSTAT: begin
                if (off == 3'd0)
                    rdata = {port_status[int'(pidx)*STAT_W +: STAT_W], 4'b0};
                else if (off == 3'd1)
                    rdata = {7'b0, inten_q[pidx]};
            end
            WIN_VID:  rdata = vid_byte(off);
            WIN_VDEP: rdata = vdep_q[off];
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/prf_checker.sv
module prf_checker #(
    parameter int NPORT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       addr,
    input logic             wr_en,
    input logic [7:0]       wdata,
    input logic [7:0]       rdata,
    input logic [NPORT-1:0] port_resume,
    input logic             arb_timeout,
    input logic             susp_mode,
    input logic             tmo_q,
    input logic             evt_q,
    input logic             wdog_q,
    input logic [2:0]       sel_page
);
    p_tmo_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arb_timeout |=> tmo_q);

    p_tmo_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'd5 && wdata[7] && !arb_timeout) |=> !tmo_q);

    p_evt_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!susp_mode && !evt_q) |=> !evt_q);

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_mode && wdog_q && (|port_resume)) |=> evt_q);

    p_sel_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 4'd7) |-> (rdata[4] == 1'b0));

    p_unused_page_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[3] && sel_page != 3'd0 && sel_page != 3'd1 && sel_page != 3'd7)
        |-> (rdata == 8'h00));
endmodule

bind phy_regfile prf_checker #(.NPORT(NPORT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .wdata       (wdata),
    .rdata       (rdata),
    .port_resume (port_resume),
    .arb_timeout (arb_timeout),
    .susp_mode   (susp_mode),
    .tmo_q       (tmo_q),
    .evt_q       (evt_q),
    .wdog_q      (wdog_q),
    .sel_page    (sel_page)
);

// File: tb/sim_phy_regfile.sv
module sim_phy_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] port_status = '0;
    logic [1:0] port_resume = '0;
    logic       arb_timeout = 1'b0;
    logic       susp_mode = 1'b1;
    logic       accel_en, multi_en;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    phy_regfile u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .port_status(port_status), .port_resume(port_resume),
        .arb_timeout(arb_timeout), .susp_mode(susp_mode),
        .accel_en(accel_en), .multi_en(multi_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp_v);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [7:0] exp_v);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, rdata, exp_v);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd("R1", 4'd5, 8'h00);
        rd("R1", 4'd6, 8'h00);
        rd("R1", 4'd7, 8'h00);
        chk("R1 accel_en", {7'b0, accel_en}, 8'h00);
        chk("R1 multi_en", {7'b0, multi_en}, 8'h00);
        wr(4'd7, 8'hE1);
        rd("R1", 4'd8, 8'h00);
        wr(4'd7, 8'h01);
        rd("R1", 4'd9, 8'h00);
        wr(4'd7, 8'h00);
    endtask

    task automatic t_ctrl_r7();
        wr(4'd5, 8'h03);
        rd("R7", 4'd5, 8'h03);
        chk("R7 accel_en", {7'b0, accel_en}, 8'h01);
        chk("R7 multi_en", {7'b0, multi_en}, 8'h01);
        wr(4'd5, 8'h3E);
        rd("R7", 4'd5, 8'h02);
        chk("R7 multi_en off", {7'b0, multi_en}, 8'h00);
        wr(4'd5, 8'h00);
    endtask

    task automatic t_select_r8();
        wr(4'd7, 8'hFF);
        rd("R8", 4'd7, 8'hEF);
        wr(4'd7, 8'h00);
        rd("R8", 4'd7, 8'h00);
    endtask

    task automatic t_base_r13();
        for (int a = 0; a < 5; a++) wr(4'(a), 8'hFF);
        for (int a = 0; a < 5; a++) rd("R13", 4'(a), 8'h00);
        rd("R13 flags untouched", 4'd5, 8'h00);
    endtask

    task automatic t_pstat_r9();
        port_status = 8'h7A;
        wr(4'd7, 8'h00);
        rd("R9 port0 status", 4'd8, 8'hA0);
        wr(4'd7, 8'h01);
        rd("R9 port1 status", 4'd8, 8'h70);
        wr(4'd9, 8'h01);
        rd("R9 port1 inten", 4'd9, 8'h01);
        wr(4'd7, 8'h00);
        rd("R9 port0 inten", 4'd9, 8'h00);
    endtask

    task automatic t_event_r3();
        wr(4'd5, 8'hC0);
        rd("R3 clear", 4'd5, 8'h00);
        @(negedge clk); port_status = 8'h7B;
        step(); step();
        rd("R3 masked port", 4'd5, 8'h00);
        @(negedge clk); port_status = 8'h6B;
        step();
        rd("R3 enabled port", 4'd5, 8'h40);
        wr(4'd5, 8'h40);
        step(); step();
        rd("R3 single event", 4'd5, 8'h00);
    endtask

    task automatic t_suspend_r5();
        wr(4'd6, 8'h01);
        @(negedge clk); susp_mode = 1'b0; port_status = 8'h7B;
        step();
        @(negedge clk); port_resume = 2'b01;
        @(negedge clk); port_resume = 2'b00;
        step();
        rd("R5 blocked", 4'd5, 8'h00);
        susp_mode = 1'b1;
        wr(4'd6, 8'h00);
    endtask

    task automatic t_resume_r4();
        rd("R4 wdog rd", 4'd6, 8'h00);
        @(negedge clk); port_resume = 2'b10;
        @(negedge clk); port_resume = 2'b00;
        rd("R4 no watchdog", 4'd5, 8'h00);
        wr(4'd6, 8'h01);
        rd("R4 wdog set", 4'd6, 8'h01);
        @(negedge clk); port_resume = 2'b10;
        @(negedge clk); port_resume = 2'b00;
        rd("R4 watchdog resume", 4'd5, 8'h40);
        wr(4'd5, 8'h40);
        rd("R4 cleared", 4'd5, 8'h00);
    endtask

    task automatic t_set_wins_r6();
        @(negedge clk);
        addr = 4'd5; wdata = 8'h40; wr_en = 1'b1; port_resume = 2'b01;
        @(negedge clk);
        wr_en = 1'b0; port_resume = 2'b00;
        rd("R6 set over clear", 4'd5, 8'h40);
        wr(4'd5, 8'h40);
        wr(4'd6, 8'h00);
        rd("R6 cleared", 4'd5, 8'h00);
    endtask

    task automatic t_timeout_r2();
        @(negedge clk); arb_timeout = 1'b1;
        @(negedge clk); arb_timeout = 1'b0;
        rd("R2 set", 4'd5, 8'h80);
        wr(4'd5, 8'h00);
        rd("R2 write0 no effect", 4'd5, 8'h80);
        wr(4'd5, 8'h80);
        rd("R2 w1c", 4'd5, 8'h00);
    endtask

    task automatic t_vid_r10();
        logic [47:0] ids;
        ids = {24'h00A0B1, 24'h5C2D3E};
        wr(4'd7, 8'h2F);
        for (int i = 0; i < 6; i++) rd("R10", 4'(8 + i), ids[47 - 8*i -: 8]);
        rd("R10 pad", 4'd14, 8'h00);
        rd("R10 pad", 4'd15, 8'h00);
    endtask

    task automatic t_vdep_r11();
        wr(4'd7, 8'hE1);
        for (int i = 0; i < 8; i++) wr(4'(8 + i), 8'(8'h11 * (i + 1)));
        for (int i = 0; i < 8; i++) rd("R11", 4'(8 + i), 8'(8'h11 * (i + 1)));
        wr(4'd7, 8'hE0);
        rd("R11 wrong port", 4'd8, 8'h00);
        wr(4'd8, 8'h55);
        wr(4'd7, 8'hE1);
        rd("R11 write ignored", 4'd8, 8'h11);
    endtask

    task automatic t_unused_r12();
        wr(4'd7, 8'h40);
        rd("R12 page2", 4'd8, 8'h00);
        wr(4'd9, 8'hAA);
        wr(4'd7, 8'hA0);
        wr(4'd10, 8'hBB);
        wr(4'd7, 8'hE1);
        rd("R12 page2 write ignored", 4'd9, 8'h22);
        rd("R12 page5 write ignored", 4'd10, 8'h33);
        wr(4'd7, 8'h05);
        rd("R12 port5", 4'd8, 8'h00);
        wr(4'd9, 8'h00);
        wr(4'd7, 8'h01);
        rd("R12 port5 write ignored", 4'd9, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_r7();
        t_select_r8();
        t_base_r13();
        t_pstat_r9();
        t_event_r3();
        t_suspend_r5();
        t_resume_r4();
        t_set_wins_r6();
        t_timeout_r2();
        t_vid_r10();
        t_vdep_r11();
        t_unused_r12();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule